// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

While a bus transceiver sits in its low-power standby state, this block watches the sampled differential-bus level. It decides whether a remote node has sent a wake request. A level 0 on the bus input means dominant and a level 1 means recessive. The raw level first passes through an input filter, which removes any phase shorter than a configured number of cycles. A three-step matcher then looks for a qualified dominant phase, a qualified recessive phase and a second qualified dominant phase. The whole sequence must finish inside a configured window that starts at the first dominant edge.

On success the block emits a one-cycle wake event and sets a wake-latched flag. From then on its receive-data output follows the filtered bus level. Until that moment the receive-data output is held high in standby. Three things silently drop a pattern in progress: leaving standby, a supply undervoltage, and the window running out. The bus must then send the full pattern again. In normal mode the matcher is idle and the receive-data output simply follows the filtered bus.

All durations are parameters counted in clock cycles: the filter time `FILT_CYC`, the dominant minimum `DOM_MIN`, the recessive minimum `REC_MIN` and the window `WAKE_TMO`.

Top module: `bus_wake_detect`

## Requirements
- R1: While reset is asserted, and directly after it, `rxd` is 1, `wakePulse` is 0 and `wakeLatched` is 0.
- R2: The filtered level changes only after the bus input has differed from it on `FILT_CYC` consecutive clock edges. A shorter excursion never reaches the matcher or `rxd`. A qualifying change appears on `rxd` (when `rxd` follows the bus) `FILT_CYC` cycles after it was first driven.
- R3: A wake is recognised for a dominant phase of D ≥ `DOM_MIN` cycles, then a recessive phase of R ≥ `REC_MIN` cycles, then a dominant phase of at least `DOM_MIN` cycles. `wakePulse` rises at the clock edge that comes `FILT_CYC`+D+R+`DOM_MIN`−1 edges after the edge that first samples the first dominant level.
- R4: Between qualified phases, dominant or recessive excursions (each at least `FILT_CYC` long) that are shorter than the minimum of the phase being sought neither advance nor break the sequence.
- R5: A wake is recognised only if D+R+`DOM_MIN` ≤ `WAKE_TMO` (lengths of the filtered phases). Otherwise the matcher returns to idle, and a new dominant edge is needed to start again.
- R6: In standby before a wake, `rxd` stays 1.
- R7: After a wake, and while standby persists, `wakeLatched` stays 1 and `rxd` equals the bus input delayed by `FILT_CYC` cycles.
- R8: Leaving standby (`standbyMode` = 0) aborts any pattern in progress without a wake. It clears `wakeLatched` on the next edge. No `wakePulse` is produced in normal mode.
- R9: `underVolt` high on any edge during a pattern aborts it without a wake, and no `wakePulse` follows an edge that sampled `underVolt` high.
- R10: `wakePulse` is high for exactly one cycle per recognised pattern.
- R11: In normal mode, `rxd` equals the bus input delayed by `FILT_CYC` cycles and `wakeLatched` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| busLvl | input | 1 | Sampled bus level, 0 = dominant, 1 = recessive |
| standbyMode | input | 1 | 1 = low-power standby, 0 = normal mode |
| underVolt | input | 1 | Supply undervoltage indication, active high |
| wakePulse | output | 1 | One-cycle wake event |
| wakeLatched | output | 1 | Wake seen; held until standby is left |
| rxd | output | 1 | Receive-data output |

## Verification
The hardest case to reach is a sequence that completes on the very last cycle of the window. Next to it is the case that misses that cycle by one, while the first two phases are each long enough. Hitting those two requires exact phase lengths, not random traffic. The bench therefore sweeps every combination of first-phase and gap lengths around both minimums and across the window edge, in a small configuration. For each one it predicts, by arithmetic, the exact cycle of the pulse or its absence. Directed sequences add a short excursion inside each qualified phase, and add an abort in the middle of a pattern by mode change and by undervoltage.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DOM1,
    ST_REC,
    ST_WOKE
  } wakeState_t;

  // control -> datapath
  typedef struct packed {
    logic winClr;
    logic winRun;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic domStart;
    logic domQual;
    logic recQual;
    logic lvl;
    logic winEnd;
  } dpFlag_t;

endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int FILT_CYC = 16,
  parameter int DOM_MIN  = 128,
  parameter int REC_MIN  = 128,
  parameter int WAKE_TMO = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busLvl,
  input  ctlStrobe_t strobe,
  output dpFlag_t    flags
);

  localparam int RUN_SAT = (DOM_MIN > REC_MIN) ? DOM_MIN : REC_MIN;
  localparam int RW      = $clog2(RUN_SAT + 1);
  localparam int WW      = $clog2(WAKE_TMO + 1);

  logic fLvl;
  logic flip;

  // input filter: a level must persist FILT_CYC edges before it is taken
  generate
    if (FILT_CYC <= 1) begin : g_noFilt
      assign flip = (busLvl != fLvl);
      always_ff @(posedge clk) begin
        if (!rstN) fLvl <= 1'b1;
        else       fLvl <= busLvl;
      end
    end else begin : g_filt
      localparam int FCW = $clog2(FILT_CYC + 1);
      logic [FCW-1:0] fCnt;
      assign flip = (busLvl != fLvl) && (fCnt == FCW'(FILT_CYC - 1));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          fLvl <= 1'b1;
          fCnt <= '0;
        end else if (busLvl == fLvl) begin
          fCnt <= '0;
        end else if (flip) begin
          fLvl <= busLvl;
          fCnt <= '0;
        end else begin
          fCnt <= fCnt + 1'b1;
        end
      end
    end
  endgenerate

  // length of the current filtered phase, saturating
  logic [RW-1:0] runLen;
  always_ff @(posedge clk) begin
    if (!rstN)                          runLen <= RW'(RUN_SAT);
    else if (flip)                      runLen <= '0;
    else if (runLen != RW'(RUN_SAT))    runLen <= runLen + 1'b1;
  end

  // overall completion window
  logic [WW-1:0] winCnt;
  always_ff @(posedge clk) begin
    if (!rstN || strobe.winClr)                     winCnt <= '0;
    else if (strobe.winRun && winCnt != WW'(WAKE_TMO)) winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    flags.domStart = flip && fLvl;
    flags.domQual  = !fLvl && (runLen >= RW'(DOM_MIN - 1));
    flags.recQual  = fLvl && (runLen >= RW'(REC_MIN - 1));
    flags.lvl      = fLvl;
    flags.winEnd   = (winCnt >= WW'(WAKE_TMO - 1));
  end

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       standbyMode,
  input  logic       underVolt,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe,
  output logic       wakePulse,
  output logic       wakeLatched
);

  wakeState_t state, nextState;
  logic       pulseNext;

  always_comb begin
    nextState = state;
    pulseNext = 1'b0;
    if (!standbyMode) begin
      nextState = ST_IDLE;
    end else if (underVolt && state != ST_WOKE) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (flags.domStart) nextState = ST_ARM;
        ST_ARM: begin
          if (flags.domQual)                   nextState = ST_DOM1;
          else if (flags.lvl || flags.winEnd)  nextState = ST_IDLE;
        end
        ST_DOM1: begin
          if (flags.recQual)      nextState = ST_REC;
          else if (flags.winEnd)  nextState = ST_IDLE;
        end
        ST_REC: begin
          if (flags.domQual) begin
            nextState = ST_WOKE;
            pulseNext = 1'b1;
          end else if (flags.winEnd) begin
            nextState = ST_IDLE;
          end
        end
        ST_WOKE: nextState = ST_WOKE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wakePulse <= 1'b0;
    end else begin
      state     <= nextState;
      wakePulse <= pulseNext;
    end
  end

  always_comb begin
    strobe.winClr = (state == ST_IDLE);
    strobe.winRun = (state == ST_ARM) || (state == ST_DOM1) || (state == ST_REC);
    wakeLatched   = (state == ST_WOKE);
  end

endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect
  import wake_pkg::*;
#(
  parameter int FILT_CYC = 16,
  parameter int DOM_MIN  = 128,
  parameter int REC_MIN  = 128,
  parameter int WAKE_TMO = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic busLvl,
  input  logic standbyMode,
  input  logic underVolt,
  output logic wakePulse,
  output logic wakeLatched,
  output logic rxd
);

  ctlStrobe_t strobe;
  dpFlag_t    flags;

  wake_datapath #(
    .FILT_CYC (FILT_CYC),
    .DOM_MIN  (DOM_MIN),
    .REC_MIN  (REC_MIN),
    .WAKE_TMO (WAKE_TMO)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .busLvl (busLvl),
    .strobe (strobe),
    .flags  (flags)
  );

  wake_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .standbyMode (standbyMode),
    .underVolt   (underVolt),
    .flags       (flags),
    .strobe      (strobe),
    .wakePulse   (wakePulse),
    .wakeLatched (wakeLatched)
  );

  // held high in standby until a wake, otherwise the filtered bus
  assign rxd = (standbyMode && !wakeLatched) ? 1'b1 : flags.lvl;

endmodule

// File: rtl/bus_wake_detect_chk.sv
module bus_wake_detect_chk (
  input logic clk,
  input logic rstN,
  input logic standbyMode,
  input logic underVolt,
  input logic wakePulse,
  input logic wakeLatched,
  input logic rxd
);

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> (!wakePulse && !wakeLatched));

  p_pulse_sets_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> wakeLatched);

  p_rxd_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (standbyMode && !wakeLatched) |-> rxd);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeLatched && standbyMode) |=> wakeLatched);

  p_latch_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !standbyMode |=> !wakeLatched);

  p_normal_no_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !standbyMode |=> !wakePulse);

  p_uv_no_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> !wakePulse);

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

endmodule

bind bus_wake_detect bus_wake_detect_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .standbyMode (standbyMode),
  .underVolt   (underVolt),
  .wakePulse   (wakePulse),
  .wakeLatched (wakeLatched),
  .rxd         (rxd)
);

// File: tb/bus_wake_detect_tb.sv
`timescale 1ns/1ps
module bus_wake_detect_tb;

  localparam int F   = 2;
  localparam int DM  = 4;
  localparam int RM  = 3;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rstN, busLvl, standbyMode, underVolt;
  logic wakePulse, wakeLatched, rxd;

  always #2 clk = ~clk;

  bus_wake_detect #(
    .FILT_CYC (F),
    .DOM_MIN  (DM),
    .REC_MIN  (RM),
    .WAKE_TMO (TMO)
  ) u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .busLvl      (busLvl),
    .standbyMode (standbyMode),
    .underVolt   (underVolt),
    .wakePulse   (wakePulse),
    .wakeLatched (wakeLatched),
    .rxd         (rxd)
  );

  int    checks = 0;
  int    fails  = 0;
  int    idx    = 0;
  int    n0     = 0;
  int    expIdx = -1;
  int    chkMode = 0;
  int    pulseSeen = 0;
  string tagNow = "R6";
  bit    hist [0:255];

  function automatic bit histAt(int k);
    return hist[k & 255];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at step %0d: actual %0d expected %0d", req, what, idx, act, exp);
    end
  endtask

  // one cycle: observe outputs at the falling edge, then drive the bus
  task automatic tick(bit val);
    @(negedge clk);
    idx++;
    if (wakePulse) pulseSeen++;
    if (chkMode == 1) begin
      bit woke, eP, eR;
      string req;
      woke = (expIdx >= 0) && (idx >= expIdx);
      eP   = (idx == expIdx);
      eR   = woke ? histAt(idx - F) : 1'b1;
      if (eP)                                   req = "R3";
      else if (expIdx >= 0 && idx == expIdx + 1) req = "R10";
      else if (woke)                            req = "R7";
      else                                      req = tagNow;
      check({wakePulse, wakeLatched, rxd} == {eP, woke, eR}, req,
            "{pulse,latched,rxd}", int'({wakePulse, wakeLatched, rxd}), int'({eP, woke, eR}));
    end else if (chkMode == 2) begin
      check({wakePulse, wakeLatched, rxd} == {1'b0, 1'b0, histAt(idx - F)}, "R11",
            "normal {pulse,latched,rxd}", int'({wakePulse, wakeLatched, rxd}),
            int'({1'b0, 1'b0, histAt(idx - F)}));
    end
    busLvl = val;
    hist[idx & 255] = val;
  endtask

  task automatic ticks(bit val, int n);
    repeat (n) tick(val);
  endtask

  task automatic settle();
    chkMode = 0;
    underVolt = 1'b0;
    standbyMode = 1'b0;
    ticks(1'b1, 3);
    standbyMode = 1'b1;
    ticks(1'b1, F + 2);
  endtask

  task automatic runPattern(int d, int r, bit expectWake, string t);
    settle();
    tagNow = t;
    n0 = idx + 1;
    expIdx = expectWake ? (n0 + F + d + r + DM) : -1;
    chkMode = 1;
    ticks(1'b0, d);
    ticks(1'b1, r);
    ticks(1'b0, DM + 2);
    ticks(1'b1, TMO + F + 4);
    chkMode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    busLvl = 1'b1;
    standbyMode = 1'b1;
    underVolt = 1'b0;
    for (int i = 0; i < 256; i++) hist[i] = 1'b1;
    repeat (3) @(negedge clk);
    check({wakePulse, wakeLatched, rxd} == 3'b001, "R1", "reset outputs",
          int'({wakePulse, wakeLatched, rxd}), 1);
    rstN = 1'b1;
    @(negedge clk);
    check({wakePulse, wakeLatched, rxd} == 3'b001, "R1", "after reset outputs",
          int'({wakePulse, wakeLatched, rxd}), 1);

    // sweep over phase lengths, across both minimums and the window edge
    for (int d = 2; d <= 8; d++) begin
      for (int r = 2; r <= 14; r++) begin
        bit w;
        string t;
        w = (d >= DM) && (r >= RM) && (d + r + DM <= TMO);
        if (d < DM || r < RM)      t = "R4";
        else if (!w)               t = "R5";
        else                       t = "R6";
        runPattern(d, r, w, t);
      end
    end

    // R4: short recessive excursion while seeking the gap, completes at cycle 16
    settle(); tagNow = "R4"; n0 = idx + 1; expIdx = n0 + F + 17; chkMode = 1;
    ticks(1'b0, 5); ticks(1'b1, 2); ticks(1'b0, 2); ticks(1'b1, 4);
    ticks(1'b0, 6); ticks(1'b1, TMO + 6); chkMode = 0;

    // R4: short dominant excursion while seeking the final phase, completes at cycle 17
    settle(); tagNow = "R4"; n0 = idx + 1; expIdx = n0 + F + 18; chkMode = 1;
    ticks(1'b0, 5); ticks(1'b1, 4); ticks(1'b0, 2); ticks(1'b1, 3);
    ticks(1'b0, 6); ticks(1'b1, TMO + 6); chkMode = 0;

    // R2: one-cycle dominant blips never reach the matcher
    settle(); tagNow = "R2"; expIdx = -1; chkMode = 1;
    repeat (20) begin tick(1'b0); tick(1'b1); end
    ticks(1'b1, TMO); chkMode = 0;

    // wake, then R2 filtering on rxd while following the bus
    settle(); tagNow = "R6"; n0 = idx + 1; expIdx = n0 + F + 5 + 4 + DM; chkMode = 1;
    ticks(1'b0, 5); ticks(1'b1, 4); ticks(1'b0, 8); chkMode = 0;
    tick(1'b1);
    repeat (4) begin
      tick(1'b0);
      check(rxd == 1'b0, "R2", "rxd after 1-cycle blip", int'(rxd), 0);
    end
    tick(1'b1); tick(1'b1);
    tick(1'b0); check(rxd == 1'b1, "R2", "rxd after 2-cycle recessive", int'(rxd), 1);
    tick(1'b0); check(rxd == 1'b1, "R2", "rxd recessive held", int'(rxd), 1);
    tick(1'b0); check(rxd == 1'b0, "R2", "rxd back to dominant", int'(rxd), 0);
    check(wakeLatched == 1'b1, "R7", "latch held", int'(wakeLatched), 1);
    standbyMode = 1'b0;
    tick(1'b1);
    check(wakeLatched == 1'b0, "R8", "latch cleared on leaving standby", int'(wakeLatched), 0);

    // R11 and R8: a full pattern in normal mode wakes nothing, rxd follows bus
    settle(); standbyMode = 1'b0; ticks(1'b1, F + 2); chkMode = 2;
    ticks(1'b0, 5); ticks(1'b1, 4); ticks(1'b0, 8); ticks(1'b1, 6); chkMode = 0;

    // R8: mode change during a pattern aborts it
    settle(); pulseSeen = 0;
    ticks(1'b0, 5); ticks(1'b1, 4);
    standbyMode = 1'b0; ticks(1'b1, 2); standbyMode = 1'b1;
    ticks(1'b0, 8); ticks(1'b1, TMO + 6);
    check(pulseSeen == 0, "R8", "pulses after mode abort", pulseSeen, 0);
    check(wakeLatched == 1'b0, "R8", "latch after mode abort", int'(wakeLatched), 0);

    // R9: undervoltage during a pattern aborts it
    settle(); pulseSeen = 0;
    ticks(1'b0, 5); ticks(1'b1, 4);
    underVolt = 1'b1; tick(1'b1); underVolt = 1'b0;
    ticks(1'b0, 8); ticks(1'b1, TMO + 6);
    check(pulseSeen == 0, "R9", "pulses after undervoltage abort", pulseSeen, 0);
    check(wakeLatched == 1'b0, "R9", "latch after undervoltage abort", int'(wakeLatched), 0);

    // after an abort the full pattern is accepted again (R5 rearm)
    runPattern(5, 4, 1'b1, "R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule